// File: doc/BRIEF.md
# Mode-Selectable Frame Output Formatter

This block moves one stored detector frame onto a 32-bit valid/ready word stream each time a controller commands it. The frame sits in two external show-ahead FIFOs: one holds one length entry per frame, the other holds the payload words. A start pulse, sampled together with a two-bit mode and three header fields (frame status, debug and timestamp), begins a transaction. The block raises busy until the transaction ends and then pulses done for one cycle.

There are three modes. Full mode takes the frame length from the length FIFO. It then emits a five-word header: the all-ones marker, status, debug, timestamp, and the length. The payload words follow, and the final word carries the last flag. Header-only mode emits the same five words with a length word of zero and touches neither FIFO. Discard mode takes the length entry and pops that many payload words. It never raises output valid, which frees one frame's storage.

The sequencer states are IDLE, GETLEN (wait for and pop a length entry), MARK, STAT, DBG, STMP and LENW (the five header words), BODY (payload streaming), DROP (silent payload discard) and FIN (done pulse). The transitions are as follows. IDLE goes to GETLEN on start in Full or Discard mode and to MARK on start in Header-only mode. GETLEN goes to MARK in Full mode, to DROP in Discard mode with a nonzero length, and to FIN in Discard mode with a zero length. Each header state advances to the next one when its word is accepted. LENW goes to FIN if the length is zero and to BODY otherwise. BODY and DROP go to FIN after the final word, or at once if the data FIFO runs dry. FIN returns to IDLE.

Top module: `frame_emitter`

## Requirements
- R1: After reset, busy, done, output valid, last, both FIFO pops and the length-error flag are all 0.
- R2: Start is taken only while busy is 0. When it is taken, busy is 1 from the next cycle until the cycle after done. A start while busy is 1 has no effect on the stream or the FIFOs.
- R3: Mode encoding is 0 = Full, 1 = Header-only, 2 = Discard, 3 = Header-only. In Full mode the block pops exactly one length entry. It then emits 0xFFFFFFFF, status, debug, timestamp (all captured at start) and the length zero-extended to 32 bits, in that order, followed by exactly that many payload words in FIFO order.
- R4: Header-only mode emits the five header words with a length word of 0 and pops neither FIFO.
- R5: Discard mode pops one length entry and then that many data words. Output valid stays 0 for the whole transaction.
- R6: The last flag is 1 on the final word of a transaction and 0 on every other word. The final word is the length word when no payload follows.
- R7: While valid is 1 and ready is 0, the word and the last flag hold in the next cycle. In Full mode the data FIFO is popped only in a cycle where a payload word is accepted.
- R8: Done is a single-cycle pulse at the end of each taken command, and busy is 0 in the following cycle.
- R9: If the data FIFO is empty while payload words are still owed (Full or Discard), the length-error flag is set and the transaction ends with done. The flag stays 1 until the next start is taken.
- R10: In Full or Discard mode, while the length FIFO is empty the block waits with busy at 1, valid at 0 and no pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Command pulse from the controller |
| mode_i | input | 2 | Transmission mode, sampled with start |
| status_i | input | 32 | Frame status word, sampled with start |
| debug_i | input | 32 | Debug word, sampled with start |
| stamp_i | input | 32 | Timestamp, sampled with start |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| len_err_o | output | 1 | Data FIFO ran dry before the counted length |
| len_empty_i | input | 1 | Length FIFO empty |
| len_data_i | input | LEN_W | Length FIFO head entry |
| len_pop_o | output | 1 | Length FIFO pop |
| dat_empty_i | input | 1 | Data FIFO empty |
| dat_data_i | input | 32 | Data FIFO head word |
| dat_pop_o | output | 1 | Data FIFO pop |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 32 | Output word |
| out_last_o | output | 1 | Final word of the transaction |
| out_ready_i | input | 1 | Downstream accepts the word |

## Verification
A sequencer stuck in or skipping a header state shows up in the captured stream within the same transaction. The stream then has a misordered or missing marker, status, debug, timestamp or length word, or the last flag sits on the wrong word. A payload counter that is off by one shows up when the transaction finishes. The stream then has the wrong word count, and the FIFO read pointers end one entry off, which also corrupts the next frame. A pop that fires during backpressure loses a word, which shows as a gap in the payload sequence in the first stalled cycle. A Discard sequence that raises valid, or a stale error flag, is visible on the first cycle it occurs.

// File: rtl/fe_pkg.sv
package fe_pkg;
    typedef enum logic [1:0] {
        M_FULL  = 2'd0,
        M_HDR   = 2'd1,
        M_DROP  = 2'd2,
        M_HDR2  = 2'd3
    } fe_mode_e;

    typedef enum logic [3:0] {
        S_IDLE, S_GETLEN, S_MARK, S_STAT, S_DBG,
        S_STMP, S_LENW, S_BODY, S_DROP, S_FIN
    } fe_state_e;

    typedef enum logic [2:0] {
        H_MARK, H_STAT, H_DBG, H_STMP, H_LEN
    } fe_hsel_e;
endpackage

// File: rtl/fe_word_count.sv
module fe_word_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] value,
    output logic         is_zero,
    output logic         is_one
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - ONE;
    end

    assign value   = cnt_q;
    assign is_zero = (cnt_q == '0);
    assign is_one  = (cnt_q == ONE);
endmodule

// File: rtl/fe_hdr_bank.sv
module fe_hdr_bank
    import fe_pkg::*;
#(
    parameter int          DW     = 32,
    parameter int          LEN_W  = 16,
    parameter logic [DW-1:0] MARKER = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [DW-1:0]    status_i,
    input  logic [DW-1:0]    debug_i,
    input  logic [DW-1:0]    stamp_i,
    input  logic [LEN_W-1:0] len_i,
    input  fe_hsel_e         sel,
    output logic [DW-1:0]    word_o
);
    localparam int NFLD = 3;

    logic [DW-1:0] fin  [NFLD];
    logic [DW-1:0] fld_q[NFLD];

    assign fin[0] = status_i;
    assign fin[1] = debug_i;
    assign fin[2] = stamp_i;

    for (genvar g = 0; g < NFLD; g++) begin : g_fld
        always_ff @(posedge clk) begin
            if (!rst_n)
                fld_q[g] <= '0;
            else if (capture)
                fld_q[g] <= fin[g];
        end
    end

    always_comb begin
        unique case (sel)
            H_MARK:  word_o = MARKER;
            H_STAT:  word_o = fld_q[0];
            H_DBG:   word_o = fld_q[1];
            H_STMP:  word_o = fld_q[2];
            H_LEN:   word_o = DW'(len_i);
            default: word_o = '0;
        endcase
    end
endmodule

// File: rtl/frame_emitter.sv
module frame_emitter
    import fe_pkg::*;
#(
    parameter int DW    = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic [DW-1:0]    status_i,
    input  logic [DW-1:0]    debug_i,
    input  logic [DW-1:0]    stamp_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             len_err_o,
    input  logic             len_empty_i,
    input  logic [LEN_W-1:0] len_data_i,
    output logic             len_pop_o,
    input  logic             dat_empty_i,
    input  logic [DW-1:0]    dat_data_i,
    output logic             dat_pop_o,
    output logic             out_valid_o,
    output logic [DW-1:0]    out_data_o,
    output logic             out_last_o,
    input  logic             out_ready_i
);
    fe_state_e        state_q, state_d;
    fe_mode_e         mode_q;
    logic             err_q;
    logic             take;
    logic             cnt_load, cnt_zero, cnt_one;
    logic [LEN_W-1:0] cnt_val, cnt_init;
    logic [DW-1:0]    hdr_word;
    fe_hsel_e         hsel;

    assign take = (state_q == S_IDLE) && start_i;

    fe_word_count #(.W(LEN_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_init),
        .dec(dat_pop_o), .value(cnt_val), .is_zero(cnt_zero), .is_one(cnt_one)
    );

    fe_hdr_bank #(.DW(DW), .LEN_W(LEN_W)) u_hdr (
        .clk(clk), .rst_n(rst_n), .capture(take), .status_i(status_i),
        .debug_i(debug_i), .stamp_i(stamp_i), .len_i(cnt_val),
        .sel(hsel), .word_o(hdr_word)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_FULL;
            err_q  <= 1'b0;
        end else begin
            if (take) begin
                mode_q <= fe_mode_e'(mode_i);
                err_q  <= 1'b0;
            end else if ((state_q == S_BODY || state_q == S_DROP) && dat_empty_i) begin
                err_q  <= 1'b1;
            end
        end
    end

    // Next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:
                if (start_i)
                    state_d = (mode_i == M_FULL || mode_i == M_DROP) ? S_GETLEN : S_MARK;
            S_GETLEN:
                if (!len_empty_i) begin
                    if (mode_q == M_DROP)
                        state_d = (len_data_i == '0) ? S_FIN : S_DROP;
                    else
                        state_d = S_MARK;
                end
            S_MARK: if (out_ready_i) state_d = S_STAT;
            S_STAT: if (out_ready_i) state_d = S_DBG;
            S_DBG:  if (out_ready_i) state_d = S_STMP;
            S_STMP: if (out_ready_i) state_d = S_LENW;
            S_LENW: if (out_ready_i) state_d = cnt_zero ? S_FIN : S_BODY;
            S_BODY:
                if (dat_empty_i)                     state_d = S_FIN;
                else if (out_ready_i && cnt_one)     state_d = S_FIN;
            S_DROP:
                if (dat_empty_i || cnt_one)          state_d = S_FIN;
            S_FIN:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o      = (state_q != S_IDLE);
        done_o      = 1'b0;
        len_pop_o   = 1'b0;
        dat_pop_o   = 1'b0;
        out_valid_o = 1'b0;
        out_last_o  = 1'b0;
        hsel        = H_MARK;
        cnt_load    = take;
        cnt_init    = '0;
        unique case (state_q)
            S_IDLE: ;
            S_GETLEN: begin
                len_pop_o = !len_empty_i;
                cnt_load  = !len_empty_i;
                cnt_init  = len_data_i;
            end
            S_MARK: begin out_valid_o = 1'b1; hsel = H_MARK; end
            S_STAT: begin out_valid_o = 1'b1; hsel = H_STAT; end
            S_DBG:  begin out_valid_o = 1'b1; hsel = H_DBG;  end
            S_STMP: begin out_valid_o = 1'b1; hsel = H_STMP; end
            S_LENW: begin
                out_valid_o = 1'b1;
                hsel        = H_LEN;
                out_last_o  = cnt_zero;
            end
            S_BODY: begin
                out_valid_o = !dat_empty_i;
                out_last_o  = !dat_empty_i && cnt_one;
                dat_pop_o   = !dat_empty_i && out_ready_i;
            end
            S_DROP: dat_pop_o = !dat_empty_i;
            S_FIN:  done_o = 1'b1;
            default: ;
        endcase
    end

    assign out_data_o = (state_q == S_BODY) ? dat_data_i : hdr_word;
    assign len_err_o  = err_q;
endmodule

// File: rtl/fe_chk.sv
module fe_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [1:0]    mode_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          dat_empty_i,
    input logic          dat_pop_o,
    input logic          out_valid_o,
    input logic [DW-1:0] out_data_o,
    input logic          out_last_o,
    input logic          out_ready_i
);
    logic [1:0] seen_mode;

    always_ff @(posedge clk) begin
        if (!rst_n)                  seen_mode <= 2'd0;
        else if (start_i && !busy_o) seen_mode <= mode_i;
    end

    // R7: word held under backpressure
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));

    // R7: a payload word is popped only when it is accepted
    a_r7_pop_accept: assert property (@(posedge clk) disable iff (!rst_n)
        dat_pop_o && out_valid_o |-> out_ready_i);

    a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        dat_pop_o |-> !dat_empty_i);

    // R8: single-cycle done, then idle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    a_r8_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R5: discard never shows a word
    a_r5_null_silent: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && seen_mode == 2'd2 |-> !out_valid_o);

    // R2: busy rises after a taken start
    a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o);
endmodule

bind frame_emitter fe_chk #(.DW(DW)) u_fe_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .busy_o(busy_o), .done_o(done_o), .dat_empty_i(dat_empty_i),
    .dat_pop_o(dat_pop_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .out_last_o(out_last_o), .out_ready_i(out_ready_i)
);

// File: tb/test_frame_emitter.sv
module test_frame_emitter;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        start_i = 0;
    logic [1:0]  mode_i = 0;
    logic [31:0] status_i = 0, debug_i = 0, stamp_i = 0;
    logic        busy_o, done_o, len_err_o;
    logic        len_empty_i, len_pop_o, dat_empty_i, dat_pop_o;
    logic [15:0] len_data_i;
    logic [31:0] dat_data_i, out_data_o;
    logic        out_valid_o, out_last_o;
    logic        out_ready_i = 1;

    int errors = 0, checks = 0;
    logic [15:0] lmem [0:15];
    logic [31:0] dmem [0:255];
    int lrd = 0, lwr = 0, drd = 0, dwr = 0;
    logic [31:0] cap_d [0:63];
    logic        cap_l [0:63];
    int ncap = 0, vcnt = 0, dcnt = 0, cyc = 0;
    int bp = 0;

    always #5 clk = ~clk;

    assign len_empty_i = (lrd == lwr);
    assign len_data_i  = lmem[lrd % 16];
    assign dat_empty_i = (drd == dwr);
    assign dat_data_i  = dmem[drd % 256];

    frame_emitter i_frame_emitter (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .status_i(status_i), .debug_i(debug_i), .stamp_i(stamp_i),
        .busy_o(busy_o), .done_o(done_o), .len_err_o(len_err_o),
        .len_empty_i(len_empty_i), .len_data_i(len_data_i), .len_pop_o(len_pop_o),
        .dat_empty_i(dat_empty_i), .dat_data_i(dat_data_i), .dat_pop_o(dat_pop_o),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_last_o(out_last_o),
        .out_ready_i(out_ready_i)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (out_valid_o && out_ready_i) begin
                cap_d[ncap % 64] <= out_data_o;
                cap_l[ncap % 64] <= out_last_o;
                ncap <= ncap + 1;
            end
            if (out_valid_o) vcnt <= vcnt + 1;
            if (done_o)      dcnt <= dcnt + 1;
            if (len_pop_o)   lrd  <= lrd + 1;
            if (dat_pop_o)   drd  <= drd + 1;
        end
    end

    always @(negedge clk) begin
        if (bp == 0)      out_ready_i <= 1'b1;
        else if (bp == 1) out_ready_i <= (cyc % 3) != 0;
        else              out_ready_i <= 1'b0;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_frame(input int len, input int nwords, input logic [31:0] base);
        lmem[lwr % 16] = 16'(len);
        lwr++;
        for (int i = 0; i < nwords; i++) begin
            dmem[dwr % 256] = base + 32'(i);
            dwr++;
        end
    endtask

    task automatic issue(input logic [1:0] m);
        @(negedge clk);
        mode_i  = m;
        start_i = 1;
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic wait_done(input int d0, input string req);
        int n = 0;
        while (dcnt == d0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(dcnt == d0 + 1, req, 32'(dcnt), 32'(d0 + 1));
        @(negedge clk);
        chk(busy_o == 0, "R8 busy low after done", 32'(busy_o), 0);
    endtask

    task automatic check_header(input int c0, input int len, input string req);
        chk(cap_d[c0 % 64] == 32'hFFFFFFFF, req, cap_d[c0 % 64], 32'hFFFFFFFF);
        chk(cap_d[(c0+1) % 64] == status_i, req, cap_d[(c0+1) % 64], status_i);
        chk(cap_d[(c0+2) % 64] == debug_i, req, cap_d[(c0+2) % 64], debug_i);
        chk(cap_d[(c0+3) % 64] == stamp_i, req, cap_d[(c0+3) % 64], stamp_i);
        chk(cap_d[(c0+4) % 64] == 32'(len), req, cap_d[(c0+4) % 64], 32'(len));
    endtask

    task automatic t_full(input int len, input int bpm, input logic [31:0] base);
        int c0, l0, d0, dn0;
        bit lastok = 1;
        status_i = base ^ 32'h0F0F; debug_i = base + 7; stamp_i = 32'(cyc);
        bp = bpm;
        push_frame(len, len, base);
        c0 = ncap; l0 = lrd; d0 = drd; dn0 = dcnt;
        issue(2'd0);
        chk(len_err_o == 0, "R9 flag clear after start", 32'(len_err_o), 0);
        wait_done(dn0, "R8 done once full");
        chk(ncap - c0 == len + 5, "R3 word count", 32'(ncap - c0), 32'(len + 5));
        check_header(c0, len, "R3 header");
        for (int i = 0; i < len; i++)
            chk(cap_d[(c0+5+i) % 64] == base + 32'(i), "R3 payload", cap_d[(c0+5+i) % 64], base + 32'(i));
        for (int i = 0; i < len + 5; i++)
            if (cap_l[(c0+i) % 64] != (i == len + 4)) lastok = 0;
        chk(lastok, "R6 last only on final word", 32'(lastok), 1);
        chk(lrd - l0 == 1 && drd - d0 == len, "R7 pops match", 32'(drd - d0), 32'(len));
        chk(len_err_o == 0, "R9 no error", 32'(len_err_o), 0);
        bp = 0;
    endtask

    task automatic t_header_only(input logic [1:0] m);
        int c0, l0, d0, dn0;
        status_i = 32'h1234_5678; debug_i = 32'hDEAD_0001; stamp_i = 32'h0000_BEEF;
        push_frame(2, 2, 32'h7700_0000);
        c0 = ncap; l0 = lrd; d0 = drd; dn0 = dcnt;
        issue(m);
        wait_done(dn0, "R8 done once header-only");
        chk(ncap - c0 == 5, "R4 five words", 32'(ncap - c0), 5);
        check_header(c0, 0, "R4 header");
        chk(cap_l[(c0+4) % 64] == 1 && cap_l[c0 % 64] == 0, "R6 last on length word", 32'(cap_l[(c0+4) % 64]), 1);
        chk(lrd == l0 && drd == d0, "R4 no pops", 32'(lrd - l0 + drd - d0), 0);
        // drain the staged frame in discard mode
        dn0 = dcnt;
        issue(2'd2);
        wait_done(dn0, "R8 done drain");
    endtask

    task automatic t_null(input int len);
        int v0, l0, d0, dn0;
        push_frame(len, len, 32'h5500_0000);
        v0 = vcnt; l0 = lrd; d0 = drd; dn0 = dcnt;
        issue(2'd2);
        wait_done(dn0, "R8 done once discard");
        chk(vcnt == v0, "R5 valid never high", 32'(vcnt - v0), 0);
        chk(lrd - l0 == 1, "R5 one length popped", 32'(lrd - l0), 1);
        chk(drd - d0 == len, "R5 payload dropped", 32'(drd - d0), 32'(len));
    endtask

    task automatic t_underrun;
        int c0, dn0;
        status_i = 1; debug_i = 2; stamp_i = 3;
        push_frame(4, 2, 32'h3300_0000);
        c0 = ncap; dn0 = dcnt;
        issue(2'd0);
        wait_done(dn0, "R9 ends with done");
        chk(len_err_o == 1, "R9 error set", 32'(len_err_o), 1);
        chk(ncap - c0 == 7, "R9 words before underrun", 32'(ncap - c0), 7);
        repeat (3) @(negedge clk);
        chk(len_err_o == 1, "R9 error held", 32'(len_err_o), 1);
    endtask

    task automatic t_wait_len;
        int v0, dn0, c0;
        v0 = vcnt; dn0 = dcnt; c0 = ncap;
        status_i = 9; debug_i = 8; stamp_i = 7;
        issue(2'd0);
        repeat (6) @(negedge clk);
        chk(busy_o == 1, "R10 busy while waiting", 32'(busy_o), 1);
        chk(vcnt == v0, "R10 no valid while waiting", 32'(vcnt - v0), 0);
        push_frame(1, 1, 32'h4400_0000);
        wait_done(dn0, "R10 done after length arrives");
        chk(ncap - c0 == 6 && cap_d[(c0+5) % 64] == 32'h4400_0000, "R10 frame sent", cap_d[(c0+5) % 64], 32'h4400_0000);
    endtask

    task automatic t_start_busy;
        int c0, l0, dn0;
        status_i = 32'hAAAA; debug_i = 32'hBBBB; stamp_i = 32'hCCCC;
        push_frame(2, 2, 32'h6600_0000);
        push_frame(1, 1, 32'h6700_0000);
        bp = 2;
        c0 = ncap; l0 = lrd; dn0 = dcnt;
        issue(2'd0);
        repeat (3) @(negedge clk);
        chk(out_valid_o == 1 && out_data_o == 32'hFFFFFFFF, "R7 marker held", out_data_o, 32'hFFFFFFFF);
        issue(2'd2);
        bp = 0;
        wait_done(dn0, "R2 single done");
        repeat (4) @(negedge clk);
        chk(dcnt == dn0 + 1, "R2 busy start ignored", 32'(dcnt), 32'(dn0 + 1));
        chk(ncap - c0 == 7 && lrd - l0 == 1, "R2 one frame consumed", 32'(ncap - c0), 7);
        dn0 = dcnt;
        issue(2'd2);
        wait_done(dn0, "R8 drain second");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && out_valid_o == 0 && len_err_o == 0
            && len_pop_o == 0 && dat_pop_o == 0 && out_last_o == 0, "R1 reset state",
            {26'd0, busy_o, done_o, out_valid_o, len_err_o, len_pop_o, dat_pop_o}, 0);
        rst_n = 1;
        @(negedge clk);
        t_full(3, 0, 32'hA000_0000);
        t_full(6, 1, 32'hB000_0000);
        t_full(0, 0, 32'hC000_0000);
        t_header_only(2'd1);
        t_header_only(2'd3);
        t_null(4);
        t_null(0);
        t_underrun;
        t_wait_len;
        t_start_busy;
        t_full(2, 1, 32'hD000_0000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule